// File: doc/BRIEF.md
# Branch Resolution and Flush Unit

This unit sits in the execute stage of a five-stage 32-bit pipeline with no branch delay slot. Each cycle it takes the decoded control-flow fields of the instruction in execute, the instruction's PC, both register operands, the 16-bit and 26-bit immediates, and the direction and target that the front end predicted. From these it works out whether the branch or jump is taken, its target, and any link-register write.

When the prediction was wrong, it steers fetch to the correct successor and squashes the two younger instructions in fetch and decode. When the prediction was right, it leaves the front end alone. Every resolved control-flow instruction also produces a one-cycle training record for the predictor, carrying the branch PC, the actual direction and the predicted direction.

All outputs are registered. They appear in the cycle after the instruction is presented with `ex_valid` high, so the redirect and the two squash strobes line up with one another.

Top module: `br_resolve`

## Requirements
- R1: While reset is asserted, and in the first cycle after it, `res_valid`, `link_we`, `redirect`, `flush_if` and `flush_id` are low.
- R2: BEQ (opcode 4) is taken when rs equals rt. BNE (opcode 5) is taken when they differ. For both, `br_target` = PC + 4 + (sign-extended imm16 << 2).
- R3: The rs-versus-zero conditions use a signed compare. BLEZ is opcode 6 and BGTZ is opcode 7. BLTZ and BGEZ are opcode 1 with an rt field of 0 and 1. Their target follows the same rule as R2.
- R4: J (opcode 2) and JAL (opcode 3) are always taken, with target {PC[31:28], imm26, 2'b00}.
- R5: JR and JALR are opcode 0 with funct 8 and 9. Both are always taken, with target equal to the rs value. JALR writes PC + 4 into the register named by the rd field.
- R6: JAL writes PC + 4 into register 31. BLTZAL and BGEZAL (opcode 1, rt fields 16 and 17) write PC + 4 into register 31 only when taken. No other branch asserts `link_we`.
- R7: A mispredict is declared in either of two cases: the actual direction differs from the predicted one, or the branch is taken and its target differs from the predicted target. On a mispredict, `redirect`, `flush_if` and `flush_id` are all high in the cycle after the instruction was presented, and `redirect_pc` holds the actual successor: the target if taken, PC + 4 otherwise.
- R8: A correctly predicted control-flow instruction raises none of `redirect`, `flush_if` or `flush_id`.
- R9: Each valid control-flow instruction gives exactly one cycle of `res_valid`, together with `res_pc`, `res_taken` and `res_pred_taken` for that instruction. A cycle without `ex_valid` gives no pulse.
- R10: A non-control-flow instruction, or any input while `ex_valid` is low, asserts none of `res_valid`, `redirect`, the flush strobes or `link_we`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ex_valid | input | 1 | Execute stage holds a live instruction |
| ex_op | input | 6 | Primary opcode field |
| ex_funct | input | 6 | Function field (opcode 0) |
| ex_rt | input | 5 | rt field (selects the opcode-1 variant) |
| ex_rd | input | 5 | rd field (JALR link destination) |
| ex_pc | input | 32 | PC of the instruction in execute |
| ex_rs_val | input | 32 | Forwarded rs operand |
| ex_rt_val | input | 32 | Forwarded rt operand |
| ex_imm16 | input | 16 | Branch displacement in words |
| ex_imm26 | input | 26 | Jump word index |
| ex_pred_taken | input | 1 | Predicted direction |
| ex_pred_target | input | 32 | Predicted target |
| res_valid | output | 1 | One-cycle training record strobe |
| res_pc | output | 32 | PC of the resolved branch |
| res_taken | output | 1 | Actual direction |
| res_pred_taken | output | 1 | Predicted direction |
| br_target | output | 32 | Computed branch or jump target |
| link_we | output | 1 | Link register write enable |
| link_rd | output | 5 | Link register index |
| link_val | output | 32 | Return address (PC + 4) |
| redirect | output | 1 | Fetch must restart at `redirect_pc` |
| redirect_pc | output | 32 | Actual successor address |
| flush_if | output | 1 | Turn the fetch stage register into a bubble |
| flush_id | output | 1 | Turn the decode stage register into a bubble |

## Verification
The assertions assume that the operand and prediction inputs are already settled by the clock edge at which `ex_valid` is sampled. They also assume that the opcode, funct and rt fields come from one real instruction word. The bench drives every input at the falling edge and keeps it stable through the next rising edge. It issues only legal encodings, together with two ordinary non-branch opcodes. The link and flush checks therefore never meet a half-decoded field combination.

// File: rtl/br_resolve.sv
module br_resolve #(
  parameter int unsigned LINK_REG = 31
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        ex_valid,
  input  logic [5:0]  ex_op,
  input  logic [5:0]  ex_funct,
  input  logic [4:0]  ex_rt,
  input  logic [4:0]  ex_rd,
  input  logic [31:0] ex_pc,
  input  logic [31:0] ex_rs_val,
  input  logic [31:0] ex_rt_val,
  input  logic [15:0] ex_imm16,
  input  logic [25:0] ex_imm26,
  input  logic        ex_pred_taken,
  input  logic [31:0] ex_pred_target,
  output logic        res_valid,
  output logic [31:0] res_pc,
  output logic        res_taken,
  output logic        res_pred_taken,
  output logic [31:0] br_target,
  output logic        link_we,
  output logic [4:0]  link_rd,
  output logic [31:0] link_val,
  output logic        redirect,
  output logic [31:0] redirect_pc,
  output logic        flush_if,
  output logic        flush_id
);

  localparam logic [4:0] LINK_IDX   = 5'(LINK_REG);
  localparam logic [5:0] OP_SPECIAL = 6'd0;
  localparam logic [5:0] OP_REGIMM  = 6'd1;
  localparam logic [5:0] OP_J       = 6'd2;
  localparam logic [5:0] OP_JAL     = 6'd3;
  localparam logic [5:0] OP_BEQ     = 6'd4;
  localparam logic [5:0] OP_BNE     = 6'd5;
  localparam logic [5:0] OP_BLEZ    = 6'd6;
  localparam logic [5:0] OP_BGTZ    = 6'd7;
  localparam logic [5:0] FN_JR      = 6'd8;
  localparam logic [5:0] FN_JALR    = 6'd9;
  localparam logic [4:0] RI_LTZ     = 5'd0;
  localparam logic [4:0] RI_GEZ     = 5'd1;
  localparam logic [4:0] RI_LTZAL   = 5'd16;
  localparam logic [4:0] RI_GEZAL   = 5'd17;

  logic [31:0] pc_plus4, rel_tgt, abs_tgt;
  logic        rs_neg, rs_zero, ops_eq;

  assign pc_plus4 = ex_pc + 32'd4;
  assign rel_tgt  = pc_plus4 + {{14{ex_imm16[15]}}, ex_imm16, 2'b00};
  assign abs_tgt  = {ex_pc[31:28], ex_imm26, 2'b00};
  assign rs_neg   = ex_rs_val[31];
  assign rs_zero  = (ex_rs_val == 32'd0);
  assign ops_eq   = (ex_rs_val == ex_rt_val);

  logic        is_cf, act_taken, want_link;
  logic [31:0] act_tgt;
  logic [4:0]  lnk_idx;

  always_comb begin
    is_cf     = 1'b0;
    act_taken = 1'b0;
    act_tgt   = rel_tgt;
    want_link = 1'b0;
    lnk_idx   = LINK_IDX;
    unique case (ex_op)
      OP_BEQ:  begin is_cf = 1'b1; act_taken = ops_eq;            end
      OP_BNE:  begin is_cf = 1'b1; act_taken = !ops_eq;           end
      OP_BLEZ: begin is_cf = 1'b1; act_taken = rs_neg || rs_zero; end
      OP_BGTZ: begin is_cf = 1'b1; act_taken = !rs_neg && !rs_zero; end
      OP_J:    begin is_cf = 1'b1; act_taken = 1'b1; act_tgt = abs_tgt; end
      OP_JAL:  begin
        is_cf = 1'b1; act_taken = 1'b1; act_tgt = abs_tgt; want_link = 1'b1;
      end
      OP_REGIMM: begin
        unique case (ex_rt)
          RI_LTZ:   begin is_cf = 1'b1; act_taken = rs_neg;  end
          RI_GEZ:   begin is_cf = 1'b1; act_taken = !rs_neg; end
          RI_LTZAL: begin is_cf = 1'b1; act_taken = rs_neg;  want_link = rs_neg;  end
          RI_GEZAL: begin is_cf = 1'b1; act_taken = !rs_neg; want_link = !rs_neg; end
          default: ;
        endcase
      end
      OP_SPECIAL: begin
        if (ex_funct == FN_JR) begin
          is_cf = 1'b1; act_taken = 1'b1; act_tgt = ex_rs_val;
        end else if (ex_funct == FN_JALR) begin
          is_cf = 1'b1; act_taken = 1'b1; act_tgt = ex_rs_val;
          want_link = 1'b1; lnk_idx = ex_rd;
        end
      end
      default: ;
    endcase
  end

  logic hit, mispredict;
  assign hit        = ex_valid && is_cf;
  assign mispredict = act_taken ? (!ex_pred_taken || (ex_pred_target != act_tgt))
                                : ex_pred_taken;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_valid <= 1'b0;
      link_we   <= 1'b0;
      redirect  <= 1'b0;
      flush_if  <= 1'b0;
      flush_id  <= 1'b0;
    end else begin
      res_valid <= hit;
      link_we   <= hit && want_link;
      redirect  <= hit && mispredict;
      flush_if  <= hit && mispredict;
      flush_id  <= hit && mispredict;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_pc         <= '0;
      res_taken      <= 1'b0;
      res_pred_taken <= 1'b0;
      br_target      <= '0;
      link_rd        <= '0;
      link_val       <= '0;
      redirect_pc    <= '0;
    end else if (hit) begin
      res_pc         <= ex_pc;
      res_taken      <= act_taken;
      res_pred_taken <= ex_pred_taken;
      br_target      <= act_tgt;
      link_rd        <= lnk_idx;
      link_val       <= pc_plus4;
      redirect_pc    <= act_taken ? act_tgt : pc_plus4;
    end
  end

  a_r10_quiet_on_other: assert property (@(posedge clk) disable iff (!rst_n)
    (ex_valid && !is_cf) |=> (!res_valid && !redirect && !link_we && !flush_if && !flush_id));

  a_r9_no_pulse_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !ex_valid |=> !res_valid);

  a_r7_squash_with_redirect: assert property (@(posedge clk) disable iff (!rst_n)
    redirect |-> (flush_if && flush_id && res_valid));

  a_r7_dir_miss_redirects: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && (res_taken != res_pred_taken)) |-> redirect);

  a_r8_quiet_not_taken_hit: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && !res_taken && !res_pred_taken) |-> (!redirect && !flush_if && !flush_id));

  a_r6_link_return_addr: assert property (@(posedge clk) disable iff (!rst_n)
    link_we |-> (res_valid && link_val == res_pc + 32'd4));

endmodule

// File: tb/br_resolve_tb.sv
module br_resolve_tb;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ex_valid = 1'b0;
  logic [5:0]  ex_op = '0, ex_funct = '0;
  logic [4:0]  ex_rt = '0, ex_rd = '0;
  logic [31:0] ex_pc = '0, ex_rs_val = '0, ex_rt_val = '0, ex_pred_target = '0;
  logic [15:0] ex_imm16 = '0;
  logic [25:0] ex_imm26 = '0;
  logic        ex_pred_taken = 1'b0;

  logic        res_valid, res_taken, res_pred_taken, link_we, redirect, flush_if, flush_id;
  logic [31:0] res_pc, br_target, link_val, redirect_pc;
  logic [4:0]  link_rd;

  always #2.5 clk = ~clk;

  br_resolve u_dut (
    .clk(clk), .rst_n(rst_n), .ex_valid(ex_valid), .ex_op(ex_op), .ex_funct(ex_funct),
    .ex_rt(ex_rt), .ex_rd(ex_rd), .ex_pc(ex_pc), .ex_rs_val(ex_rs_val),
    .ex_rt_val(ex_rt_val), .ex_imm16(ex_imm16), .ex_imm26(ex_imm26),
    .ex_pred_taken(ex_pred_taken), .ex_pred_target(ex_pred_target),
    .res_valid(res_valid), .res_pc(res_pc), .res_taken(res_taken),
    .res_pred_taken(res_pred_taken), .br_target(br_target), .link_we(link_we),
    .link_rd(link_rd), .link_val(link_val), .redirect(redirect),
    .redirect_pc(redirect_pc), .flush_if(flush_if), .flush_id(flush_id)
  );

  typedef struct packed {
    logic [5:0]  op;
    logic [5:0]  fn;
    logic [4:0]  rt;
    logic [4:0]  rd;
    logic [31:0] pc;
    logic [31:0] rs;
    logic [31:0] rtv;
    logic [15:0] i16;
    logic [25:0] i26;
    logic        pt;
    logic [31:0] ptg;
    logic        cf;
    logic        etk;
    logic [31:0] etg;
    logic        elk;
    logic [4:0]  erd;
  } vec_t;

  localparam int NV = 15;
  localparam vec_t TBL [NV] = '{
    '{6'd4, 6'd0, 5'd0, 5'd0, 32'h1000, 32'd5, 32'd5, 16'h0004, 26'd0, 1'b1, 32'h1014, 1'b1, 1'b1, 32'h1014, 1'b0, 5'd0},
    '{6'd5, 6'd0, 5'd0, 5'd0, 32'h1000, 32'd5, 32'd5, 16'hFFFC, 26'd0, 1'b0, 32'h0, 1'b1, 1'b0, 32'h0FF4, 1'b0, 5'd0},
    '{6'd5, 6'd0, 5'd0, 5'd0, 32'h2000, 32'd1, 32'd2, 16'h0010, 26'd0, 1'b0, 32'h0, 1'b1, 1'b1, 32'h2044, 1'b0, 5'd0},
    '{6'd1, 6'd0, 5'd1, 5'd0, 32'h3000, 32'd0, 32'd0, 16'h0001, 26'd0, 1'b1, 32'h3000, 1'b1, 1'b1, 32'h3008, 1'b0, 5'd0},
    '{6'd1, 6'd0, 5'd0, 5'd0, 32'h3100, 32'hFFFFFFFF, 32'd0, 16'h0002, 26'd0, 1'b1, 32'h310C, 1'b1, 1'b1, 32'h310C, 1'b0, 5'd0},
    '{6'd7, 6'd0, 5'd0, 5'd0, 32'h4000, 32'd0, 32'd0, 16'h0003, 26'd0, 1'b1, 32'h4010, 1'b1, 1'b0, 32'h4010, 1'b0, 5'd0},
    '{6'd6, 6'd0, 5'd0, 5'd0, 32'h4100, 32'h80000000, 32'd0, 16'h0000, 26'd0, 1'b0, 32'h0, 1'b1, 1'b1, 32'h4104, 1'b0, 5'd0},
    '{6'd2, 6'd0, 5'd0, 5'd0, 32'hA0000100, 32'd0, 32'd0, 16'h0, 26'h0000040, 1'b1, 32'hA0000100, 1'b1, 1'b1, 32'hA0000100, 1'b0, 5'd0},
    '{6'd3, 6'd0, 5'd0, 5'd0, 32'h50000020, 32'd0, 32'd0, 16'h0, 26'h3FFFFFF, 1'b0, 32'h0, 1'b1, 1'b1, 32'h5FFFFFFC, 1'b1, 5'd31},
    '{6'd0, 6'd8, 5'd0, 5'd0, 32'h6000, 32'h12345678, 32'd0, 16'h0, 26'd0, 1'b1, 32'h12345678, 1'b1, 1'b1, 32'h12345678, 1'b0, 5'd0},
    '{6'd0, 6'd9, 5'd0, 5'd7, 32'h6100, 32'h00008000, 32'd0, 16'h0, 26'd0, 1'b1, 32'h0, 1'b1, 1'b1, 32'h00008000, 1'b1, 5'd7},
    '{6'd1, 6'd0, 5'd17, 5'd0, 32'h7000, 32'd5, 32'd0, 16'h0004, 26'd0, 1'b1, 32'h7014, 1'b1, 1'b1, 32'h7014, 1'b1, 5'd31},
    '{6'd1, 6'd0, 5'd16, 5'd0, 32'h7100, 32'd5, 32'd0, 16'h0004, 26'd0, 1'b0, 32'h0, 1'b1, 1'b0, 32'h7114, 1'b0, 5'd0},
    '{6'd0, 6'h20, 5'd2, 5'd3, 32'h8000, 32'd1, 32'd1, 16'h0, 26'd0, 1'b1, 32'h9999, 1'b0, 1'b0, 32'h0, 1'b0, 5'd0},
    '{6'h23, 6'd0, 5'd2, 5'd0, 32'h8100, 32'd1, 32'd1, 16'h0, 26'd0, 1'b1, 32'h9999, 1'b0, 1'b0, 32'h0, 1'b0, 5'd0}
  };

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic drive(input vec_t v, input logic vld);
    ex_valid       = vld;
    ex_op          = v.op;
    ex_funct       = v.fn;
    ex_rt          = v.rt;
    ex_rd          = v.rd;
    ex_pc          = v.pc;
    ex_rs_val      = v.rs;
    ex_rt_val      = v.rtv;
    ex_imm16       = v.i16;
    ex_imm26       = v.i26;
    ex_pred_taken  = v.pt;
    ex_pred_target = v.ptg;
  endtask

  task automatic quiet_check(input string req);
    chk({req, " res_valid"}, 32'(res_valid), 32'd0);
    chk({req, " redirect"},  32'(redirect),  32'd0);
    chk({req, " flush_if"},  32'(flush_if),  32'd0);
    chk({req, " flush_id"},  32'(flush_id),  32'd0);
    chk({req, " link_we"},   32'(link_we),   32'd0);
  endtask

  task automatic vec_check(input vec_t v);
    logic mis;
    logic [31:0] nxt;
    if (!v.cf) begin
      quiet_check("R10 non-branch");
      return;
    end
    mis = v.etk ? (!v.pt || v.ptg != v.etg) : v.pt;
    nxt = v.etk ? v.etg : v.pc + 32'd4;
    chk("R9 res_valid",       32'(res_valid),      32'd1);
    chk("R9 res_pc",          res_pc,              v.pc);
    chk("R9 res_pred_taken",  32'(res_pred_taken), 32'(v.pt));
    chk("R2/R3 direction",    32'(res_taken),      32'(v.etk));
    chk("R4/R5 target",       br_target,           v.etg);
    chk("R6 link_we",         32'(link_we),        32'(v.elk));
    if (v.elk) begin
      chk("R6 link_rd",  32'(link_rd), 32'(v.erd));
      chk("R6 link_val", link_val,     v.pc + 32'd4);
    end
    chk("R7 R8 redirect", 32'(redirect), 32'(mis));
    chk("R7 R8 flush_if", 32'(flush_if), 32'(mis));
    chk("R7 R8 flush_id", 32'(flush_id), 32'(mis));
    if (mis) chk("R7 redirect_pc", redirect_pc, nxt);
  endtask

  initial begin : watchdog
    repeat (5000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin : main
    vec_t v;
    repeat (3) @(negedge clk);
    quiet_check("R1 in reset");
    rst_n = 1'b1;
    @(negedge clk);
    quiet_check("R1 after reset");

    drive(TBL[0], 1'b1);
    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      vec_check(TBL[i]);
      if (i + 1 < NV) drive(TBL[i + 1], 1'b1);
      else drive(TBL[0], 1'b0);
    end

    @(negedge clk);
    chk("R9 single pulse", 32'(res_valid), 32'd0);

    v = TBL[2];
    drive(v, 1'b0);
    @(negedge clk);
    quiet_check("R10 ex_valid low");

    v = TBL[5];
    drive(v, 1'b1);
    @(negedge clk);
    drive(v, 1'b0);
    chk("R7 BGTZ miss redirect_pc", redirect_pc, 32'h4004);
    @(negedge clk);
    chk("R9 pulse drops", 32'(res_valid), 32'd0);
    chk("R7 redirect drops", 32'(redirect), 32'd0);

    v = TBL[11];
    v.rs = 32'h80000000;
    drive(v, 1'b1);
    @(negedge clk);
    drive(v, 1'b0);
    chk("R6 BGEZAL not taken no link", 32'(link_we), 32'd0);
    chk("R7 BGEZAL pred taken redirect", 32'(redirect), 32'd1);
    chk("R7 BGEZAL fallthrough pc", redirect_pc, 32'h7004);

    v = TBL[12];
    v.rs = 32'hFFFFFFF0;
    v.pt = 1'b1;
    v.ptg = 32'h7114;
    drive(v, 1'b1);
    @(negedge clk);
    drive(v, 1'b0);
    chk("R6 BLTZAL taken link", 32'(link_we), 32'd1);
    chk("R6 BLTZAL link_rd", 32'(link_rd), 32'd31);
    chk("R8 BLTZAL hit quiet", 32'(redirect), 32'd0);

    v = TBL[0];
    v.pt = 1'b1;
    v.ptg = 32'h1018;
    drive(v, 1'b1);
    @(negedge clk);
    drive(v, 1'b0);
    chk("R7 target-only miss", 32'(redirect), 32'd1);
    chk("R7 target-only miss pc", redirect_pc, 32'h1014);

    drive(TBL[3], 1'b1);
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    quiet_check("R1 mid-run reset");
    drive(TBL[3], 1'b0);
    rst_n = 1'b1;
    @(negedge clk);
    quiet_check("R1 after mid-run reset");

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule